// File: doc/BRIEF.md
# Pixel Histogram Accumulator with Streamed Readout

This block counts how often each pixel value occurs. Every pixel value addresses one bin of an internal count memory. When the pixel-valid input is high, that bin goes up by one. The update runs as a short read-modify-write pipeline. Back-to-back hits on the same bin are forwarded inside the pipeline, so no increment is lost. A count stops at its largest value instead of wrapping.

A falling edge on the active-low start input launches a readout pass. The pass streams the bins in rising address order, one per clock, onto a 9-bit output bus, with a valid flag. Each value can be processed on its way out:
- It can be replaced by a running cumulative sum.
- A 9-bit window of the count can be chosen, and it can be saturated.
- The bin can be cleared once it has been read.

Holding the start input low lets the pass run through every bin. Releasing it early ends the pass after fewer bins. Pixel accumulation is suspended while a pass is in flight.

After reset, the block zeroes its memory by sweeping every bin once. Configuration is a single 8-bit word, loaded with a write strobe.

Top module: `histo_engine`

## Requirements
- R1: While idle, a pixel accepted with `pixValid` high adds one to the bin addressed by `pixVal`. With `pixValid` low, no bin changes.
- R2: Accepted pixels on consecutive clocks, including hits on the same bin, each contribute exactly one increment.
- R3: A bin holds at its maximum value 2^CNT_W-1 when further pixels hit it; it does not wrap.
- R4: The first rising clock edge that samples `startN` low after it was high launches a pass, if the block is idle. `outValid` and the value of bin 0 appear after the third rising edge, counting that edge as the first. Bins follow in rising address order, one per clock. `outData` is zero whenever `outValid` is low.
- R5: If `startN` is sampled high again after being low on N edges (the launching edge included), with N below the bin count, exactly N bins are output. `outValid` falls three edges after the first edge that sees `startN` high.
- R6: If `startN` stays low, the pass outputs every bin exactly once and then ends. A falling edge on `startN` while a pass is in flight, or `startN` held low after a pass ends, starts nothing.
- R7: With `cfgWord[5]` set, each output is formed from the running sum of all bins read so far in this pass. The sum starts from zero at each launch and holds at 2^CNT_W-1 instead of overflowing.
- R8: `cfgWord[3:0]` is a shift s from 0 to 15. The 9-bit output is bits s to s+8 of the count or sum. Bits above the top of the count read as zero.
- R9: With `cfgWord[4]` set, any 1 in the count or sum above bit s+8 forces the output to 511.
- R10: `cfgWord[7:6]` is the clearing policy. Bit 6 is the first control bit and bit 7 the second. When bit 7 is 0 (codes 00 and 01 in [7:6] order), each bin output in a pass is zero afterwards. Codes 11 and 10 leave every bin unchanged.
- R11: Pixels presented while a pass is in flight are ignored.
- R12: During and after reset, `outValid` and `outData` are low. After the post-reset sweep of 2^PIX_W cycles, every bin reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pixValid | input | 1 | Pixel qualifier |
| pixVal | input | PIX_W | Pixel value, used as bin address |
| startN | input | 1 | Active-low readout start and hold |
| cfgWr | input | 1 | Loads `cfgWord` into the configuration register |
| cfgWord | input | 8 | [3:0] window shift, [4] saturate, [5] cumulative, [7:6] clearing policy |
| outData | output | 9 | Processed bin value |
| outValid | output | 1 | High while `outData` carries a bin |

## Verification
The bench builds the block with PIX_W = 6 and CNT_W = 12. A full pass is then 64 clocks, so many complete and partial passes fit in a short run. Saturating a single bin needs only about four thousand pixels. With the narrow count, shifts of 4 and above push the window past the top of the count, which exercises zero fill, and saturation triggers from ordinary bin values. The cumulative sum also reaches its ceiling within one pass.

// File: rtl/histo_pkg.sv
package histo_pkg;
  localparam int SEL_W = 4;
  localparam int OUT_W = 9;
  localparam int CFG_W = SEL_W + 4;

  // Field order matches the configuration word, least significant last.
  typedef struct packed {
    logic [1:0]       clrCode;
    logic             cumOn;
    logic             satOn;
    logic [SEL_W-1:0] sel;
  } cfg_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic pixTake;    // pixel accepted into update pipe
    logic seqRead;    // readout address valid this cycle
    logic outStage;   // readout data stage valid
    logic passStart;  // pass launched this cycle
    logic initWr;     // post-reset zeroing write
    logic clrOnRead;  // clear bins as they leave
  } strobe_t;
endpackage

// File: rtl/histo_window.sv
module histo_window
  import histo_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic [CNT_W-1:0] val,
  input  logic [SEL_W-1:0] sel,
  input  logic             satOn,
  output logic [OUT_W-1:0] win
);
  localparam int EXT_W = CNT_W + OUT_W + (1 << SEL_W);

  logic [EXT_W-1:0] shifted;
  logic             over;

  always_comb begin
    shifted = {{(EXT_W-CNT_W){1'b0}}, val} >> sel;
    over    = |shifted[EXT_W-1:OUT_W];
    win     = (satOn && over) ? {OUT_W{1'b1}} : shifted[OUT_W-1:0];
  end
endmodule

// File: rtl/histo_ctrl.sv
module histo_ctrl
  import histo_pkg::*;
#(
  parameter int PIX_W = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startN,
  input  logic             pixValid,
  input  logic             cfgWr,
  input  logic [CFG_W-1:0] cfgWord,
  output cfg_t             cfg,
  output strobe_t          strb,
  output logic [PIX_W-1:0] seqAddr,
  output logic             outValid
);
  localparam int NBINS = 1 << PIX_W;
  localparam logic [PIX_W-1:0] LAST = PIX_W'(NBINS - 1);

  typedef enum logic [1:0] {ST_INIT, ST_IDLE, ST_RUN} st_t;

  st_t  state;
  logic prevStartN;
  logic s1v;
  logic fallNow;
  logic busy;
  logic launch;
  logic clrPolicy;

  assign fallNow = prevStartN & ~startN;
  assign busy    = (state != ST_IDLE) | s1v | outValid;
  assign launch  = fallNow & ~busy;

  // Clearing policy: [1] second control bit, [0] first.
  always_comb begin
    case (cfg.clrCode)
      2'b01:   clrPolicy = 1'b1;
      2'b00:   clrPolicy = 1'b1;
      default: clrPolicy = 1'b0;
    endcase
  end

  always_comb begin
    strb.pixTake   = pixValid & ~busy & ~fallNow;
    strb.seqRead   = (state == ST_RUN);
    strb.outStage  = s1v;
    strb.passStart = launch;
    strb.initWr    = (state == ST_INIT);
    strb.clrOnRead = clrPolicy;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_INIT;
      seqAddr    <= '0;
      prevStartN <= 1'b1;
      s1v        <= 1'b0;
      outValid   <= 1'b0;
      cfg        <= '{clrCode: 2'b11, cumOn: 1'b0, satOn: 1'b0, sel: '0};
    end else begin
      prevStartN <= startN;
      s1v        <= (state == ST_RUN);
      outValid   <= s1v;
      if (cfgWr) cfg <= cfg_t'(cfgWord);
      case (state)
        ST_INIT: begin
          seqAddr <= seqAddr + 1'b1;
          if (seqAddr == LAST) state <= ST_IDLE;
        end
        ST_IDLE: begin
          if (launch) begin
            state   <= ST_RUN;
            seqAddr <= '0;
          end
        end
        ST_RUN: begin
          seqAddr <= seqAddr + 1'b1;
          if (startN || seqAddr == LAST) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R4: first valid output three edges after the launching edge
  p_first_out_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.passStart |-> ##3 outValid);

  // R5: releasing start stops address issue at the next edge
  p_release_stops_r5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && startN) |=> (state == ST_IDLE));

  // R5: valid tail lasts one more cycle after issue ends, then drops
  p_valid_tail_r5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(state == ST_RUN) |-> ##1 outValid ##1 !outValid);

  // R6: a pass only begins from a fully drained block
  p_launch_idle_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(state == ST_RUN) |-> $past(!busy));
endmodule

// File: rtl/histo_dp.sv
module histo_dp
  import histo_pkg::*;
#(
  parameter int PIX_W = 9,
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strb,
  input  logic [SEL_W-1:0] sel,
  input  logic             satOn,
  input  logic             cumOn,
  input  logic [PIX_W-1:0] seqAddr,
  input  logic [PIX_W-1:0] pixVal,
  output logic [OUT_W-1:0] outData
);
  localparam int NBINS = 1 << PIX_W;
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] binMem [NBINS];

  logic             aV, bV, lastV;
  logic [PIX_W-1:0] aAddr, bAddr, sAddr, lastAddr;
  logic [CNT_W-1:0] rdQ, lastData;
  logic [PIX_W-1:0] rdAddr, wrAddr;
  logic [CNT_W-1:0] wrData;
  logic             pixWr, clrWr, initWr, wrEn;
  logic [CNT_W-1:0] pixBase, incVal, rdVal;
  logic [CNT_W:0]   sumFull;
  logic [CNT_W-1:0] cumReg, cumNext, chosen;
  logic [OUT_W-1:0] winOut;

  // Read port: readout sequencer and pixel pipe never overlap.
  assign rdAddr = strb.seqRead ? seqAddr : aAddr;

  always_ff @(posedge clk) rdQ <= binMem[rdAddr];

  // One-deep forwarding from the previous pixel write.
  always_comb begin
    pixBase = (lastV && lastAddr == bAddr) ? lastData : rdQ;
    incVal  = (pixBase == CMAX) ? CMAX : pixBase + 1'b1;
    rdVal   = (lastV && lastAddr == sAddr) ? lastData : rdQ;
    sumFull = {1'b0, cumReg} + {1'b0, rdVal};
    cumNext = sumFull[CNT_W] ? CMAX : sumFull[CNT_W-1:0];
    chosen  = cumOn ? cumNext : rdVal;
  end

  assign pixWr  = bV;
  assign clrWr  = strb.outStage & strb.clrOnRead;
  assign initWr = strb.initWr;
  assign wrEn   = pixWr | clrWr | initWr;
  assign wrAddr = pixWr ? bAddr : (clrWr ? sAddr : seqAddr);
  assign wrData = pixWr ? incVal : '0;

  always_ff @(posedge clk) begin
    if (wrEn) binMem[wrAddr] <= wrData;
  end

  histo_window #(.CNT_W(CNT_W)) u_window (
    .val  (chosen),
    .sel  (sel),
    .satOn(satOn),
    .win  (winOut)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      aV       <= 1'b0;
      bV       <= 1'b0;
      lastV    <= 1'b0;
      aAddr    <= '0;
      bAddr    <= '0;
      sAddr    <= '0;
      lastAddr <= '0;
      lastData <= '0;
      cumReg   <= '0;
      outData  <= '0;
    end else begin
      aV       <= strb.pixTake;
      aAddr    <= pixVal;
      bV       <= aV;
      bAddr    <= aAddr;
      lastV    <= pixWr;
      lastAddr <= bAddr;
      lastData <= incVal;
      if (strb.seqRead) sAddr <= seqAddr;
      if (strb.passStart)                cumReg <= '0;
      else if (strb.outStage && cumOn)   cumReg <= cumNext;
      outData  <= strb.outStage ? winOut : '0;
    end
  end

  // R10: clearing, pixel and sweep writes never compete for the port
  p_one_writer_r10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({pixWr, clrWr, initWr}));

  // R3: an increment never wraps a bin back to zero
  p_count_no_wrap_r3: assert property (@(posedge clk) disable iff (!rstN)
    pixWr |-> (wrData != '0));
endmodule

// File: rtl/histo_engine.sv
module histo_engine
  import histo_pkg::*;
#(
  parameter int PIX_W = 9,
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pixValid,
  input  logic [PIX_W-1:0] pixVal,
  input  logic             startN,
  input  logic             cfgWr,
  input  logic [CFG_W-1:0] cfgWord,
  output logic [OUT_W-1:0] outData,
  output logic             outValid
);
  cfg_t             cfg;
  strobe_t          strb;
  logic [PIX_W-1:0] seqAddr;

  histo_ctrl #(.PIX_W(PIX_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .startN  (startN),
    .pixValid(pixValid),
    .cfgWr   (cfgWr),
    .cfgWord (cfgWord),
    .cfg     (cfg),
    .strb    (strb),
    .seqAddr (seqAddr),
    .outValid(outValid)
  );

  histo_dp #(.PIX_W(PIX_W), .CNT_W(CNT_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .sel    (cfg.sel),
    .satOn  (cfg.satOn),
    .cumOn  (cfg.cumOn),
    .seqAddr(seqAddr),
    .pixVal (pixVal),
    .outData(outData)
  );
endmodule

// File: tb/histo_engine_bench.sv
module histo_engine_bench;
  localparam int PIX_W = 6;
  localparam int CNT_W = 12;
  localparam int NB    = 1 << PIX_W;
  localparam int CMAX  = (1 << CNT_W) - 1;

  logic             clk = 1'b0;
  logic             rstN;
  logic             pixValid;
  logic [PIX_W-1:0] pixVal;
  logic             startN;
  logic             cfgWr;
  logic [7:0]       cfgWord;
  logic [8:0]       outData;
  logic             outValid;

  histo_engine #(.PIX_W(PIX_W), .CNT_W(CNT_W)) u_histo_engine (
    .clk(clk), .rstN(rstN), .pixValid(pixValid), .pixVal(pixVal),
    .startN(startN), .cfgWr(cfgWr), .cfgWord(cfgWord),
    .outData(outData), .outValid(outValid)
  );

  always #4 clk = ~clk;

  int expBin [NB];
  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;
  int bSel;
  bit bSat, bCum;
  bit [1:0] bClr;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int winF(input int v, input int s, input bit sat);
    int sh;
    sh = v >> s;
    if (sat && (sh >> 9) != 0) return 511;
    return sh & 511;
  endfunction

  task automatic setCfg(input int s, input bit sat, input bit cum, input bit [1:0] clr);
    @(negedge clk);
    pixValid = 1'b0;
    cfgWr    = 1'b1;
    cfgWord  = {clr, cum, sat, 4'(s)};
    bSel = s; bSat = sat; bCum = cum; bClr = clr;
    @(negedge clk);
    cfgWr = 1'b0;
  endtask

  task automatic sendPix(input bit v, input int p);
    @(negedge clk);
    pixValid = v;
    pixVal   = PIX_W'(p);
    if (v && expBin[p] < CMAX) expBin[p]++;
  endtask

  task automatic readOut(input int n, input bit toggleTail, input bit noise, input string tag);
    int acc, idx, val, expD;
    bit expV;
    string vTag;
    @(negedge clk);
    pixValid = 1'b0;
    startN   = 1'b0;
    acc = 0;
    vTag = (n < NB) ? "R5" : "R6";
    for (int k = 1; k <= n + 6; k++) begin
      @(negedge clk);
      expV = (k >= 3 && k <= n + 2);
      check(outValid == expV, (k == 3) ? "R4" : vTag, int'(outValid), int'(expV));
      if (expV && outValid) begin
        idx = k - 3;
        val = expBin[idx];
        if (bCum) begin
          acc += val;
          if (acc > CMAX) acc = CMAX;
          val = acc;
        end
        expD = winF(val, bSel, bSat);
        check(outData == 9'(expD), tag, int'(outData), expD);
        if (!bClr[1]) expBin[idx] = 0;
      end else if (!expV) begin
        check(outData == 9'd0, "R4", int'(outData), 0);
      end
      if (n < NB && k == n) startN = 1'b1;
      if (toggleTail && k == n + 1) startN = 1'b1;
      if (toggleTail && k == n + 2) startN = 1'b0;
      if (noise) begin
        pixValid = (k <= n) && ($urandom % 2 == 1);
        pixVal   = PIX_W'($urandom % NB);
      end
    end
    pixValid = 1'b0;
    startN   = 1'b1;
    @(negedge clk);
  endtask

  task automatic finishRun;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finishRun();
    end
  end

  initial begin
    void'($urandom(32'd7741));
    for (int i = 0; i < NB; i++) expBin[i] = 0;
    rstN = 1'b0; pixValid = 1'b0; pixVal = '0; startN = 1'b1;
    cfgWr = 1'b0; cfgWord = '0;
    bSel = 0; bSat = 0; bCum = 0; bClr = 2'b11;

    // R12: outputs quiet during reset, memory zero after sweep
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(outValid == 1'b0, "R12", int'(outValid), 0);
      check(outData == 9'd0, "R12", int'(outData), 0);
    end
    rstN = 1'b1;
    repeat (NB + 4) @(negedge clk);
    check(outValid == 1'b0, "R12", int'(outValid), 0);
    setCfg(0, 0, 0, 2'b11);
    readOut(NB, 0, 0, "R12");

    // R1: random pixel stream with gaps
    for (int i = 0; i < 400; i++) sendPix(($urandom % 4) != 0, $urandom % NB);
    readOut(NB, 0, 0, "R1");

    // R2: same-bin bursts and interleaving, last pixel right before launch
    for (int i = 0; i < 30; i++) sendPix(1, 3);
    sendPix(1, 9); sendPix(1, 9); sendPix(1, 10); sendPix(1, 9);
    sendPix(1, 10); sendPix(1, 10); sendPix(1, 0);
    readOut(NB, 0, 0, "R2");

    // R9 / R8: big bin, saturation and shifts
    for (int i = 0; i < 600; i++) sendPix(1, 7);
    setCfg(0, 1, 0, 2'b11); readOut(NB, 0, 0, "R9");
    setCfg(0, 0, 0, 2'b11); readOut(NB, 0, 0, "R8");
    setCfg(2, 0, 0, 2'b11); readOut(NB, 0, 0, "R8");
    setCfg(1, 1, 0, 2'b11); readOut(NB, 0, 0, "R9");
    setCfg(4, 0, 0, 2'b11); readOut(NB, 0, 0, "R8");
    setCfg(9, 1, 0, 2'b11); readOut(NB, 0, 0, "R8");
    setCfg(15, 0, 0, 2'b11); readOut(NB, 0, 0, "R8");

    // R7: cumulative sum
    setCfg(0, 0, 1, 2'b11); readOut(NB, 0, 0, "R7");
    setCfg(3, 1, 1, 2'b11); readOut(NB, 0, 0, "R7");
    setCfg(2, 0, 1, 2'b11); readOut(20, 0, 0, "R7");

    // R5 / R10: short pass with clear (first high, second low)
    setCfg(0, 0, 0, 2'b01); readOut(10, 0, 0, "R10");
    setCfg(0, 0, 0, 2'b11); readOut(NB, 0, 0, "R10");
    readOut(1, 0, 0, "R5");
    readOut(5, 0, 0, "R5");

    // R10: code 00 clears, code 10 keeps
    for (int i = 0; i < 200; i++) sendPix(1, $urandom % NB);
    setCfg(0, 0, 0, 2'b00); readOut(NB, 0, 0, "R10");
    setCfg(0, 0, 0, 2'b11); readOut(NB, 0, 0, "R10");
    for (int i = 0; i < 200; i++) sendPix(($urandom % 2) == 1, $urandom % NB);
    setCfg(0, 0, 0, 2'b10); readOut(NB, 0, 0, "R10");
    readOut(NB, 0, 0, "R10");

    // R11: pixels during a pass are ignored
    setCfg(0, 0, 0, 2'b11);
    readOut(NB, 0, 1, "R11");
    readOut(NB, 0, 0, "R11");

    // R6: restart attempt in the drain tail is ignored
    readOut(NB, 1, 0, "R6");

    // R3: bin saturation, then cumulative saturation
    for (int i = 0; i < CMAX + 6; i++) sendPix(1, 5);
    sendPix(0, 0);
    setCfg(9, 0, 0, 2'b11); readOut(NB, 0, 0, "R3");
    setCfg(0, 0, 0, 2'b11); readOut(NB, 0, 0, "R3");
    for (int i = 0; i < 40; i++) sendPix(1, 6);
    setCfg(3, 1, 1, 2'b11); readOut(NB, 0, 0, "R7");

    finished = 1;
    finishRun();
  end
endmodule